// File: doc/BRIEF.md
# PWM Counter Input Capture Unit

This block adds input capture to one PWM channel. It reuses the channel's own counter and does not keep a timer of its own. The capture pin is brought into the clock domain through a flop chain, and edges are found by comparing the last two synchronized samples. A rising edge stores the counter value in one holding register and a falling edge stores it in a different one. This lets software measure high time, low time and period from a single pin.

Each edge has its own interrupt enable and its own sticky flag. Each edge also has its own reload enable. When that enable is set, the block sends a one-cycle load strobe to the counter, and the counter then restarts from its period value. The stored value is always the count from before that restart. The counter may count up or down; the capture path only samples the value it is given. A channel-level capture enable turns all edge detection off. The synchronizer keeps running while detection is off, so turning the enable back on does not create a false edge.

Top module: `cap_unit`

## Requirements
- R1: A synchronized low-to-high transition of `cap_pin` stores `cnt_val` into `rise_cap` and leaves `fall_cap` unchanged.
- R2: A synchronized high-to-low transition of `cap_pin` stores `cnt_val` into `fall_cap` and leaves `rise_cap` unchanged.
- R3: `rise_flag` is set by a rising capture only if `rise_ie` is 1, and `fall_flag` is set by a falling capture only if `fall_ie` is 1. `irq` is the OR of the two flags.
- R4: A capture whose edge has its reload enable set (`rise_rld_en` or `fall_rld_en`) drives `cnt_load` high for exactly one cycle, starting in the same cycle the capture register updates. The stored value is the count before the reload.
- R5: While `cap_en` is 0, pin transitions store nothing, set no flag and raise no `cnt_load`. Setting `cap_en` back to 1 after the pin has changed level while disabled produces no capture.
- R6: Each flag stays at 1 until a one-cycle pulse on its own clear input (`flag_clr_rise` or `flag_clr_fall`). A clear affects only its own flag.
- R7: If a flag set and that flag's clear happen in the same cycle, the flag ends at 1.
- R8: After synchronous reset, both capture registers read 0 and `rise_flag`, `fall_flag`, `irq` and `cnt_load` are 0.
- R9: With the default two-stage synchronizer, the capture register, flag and `cnt_load` update on the third rising clock edge after the pin change. They are unchanged after the second edge. This holds for any count value from 0x0000 to 0xFFFF, whether the counter is counting up or down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture input |
| cap_en | input | 1 | Enables edge detection for this channel |
| cnt_val | input | CNT_W | Current value of the shared PWM counter |
| rise_ie | input | 1 | Rising-capture interrupt enable |
| fall_ie | input | 1 | Falling-capture interrupt enable |
| rise_rld_en | input | 1 | Reload the counter on a rising capture |
| fall_rld_en | input | 1 | Reload the counter on a falling capture |
| flag_clr_rise | input | 1 | One-cycle clear of the rising flag |
| flag_clr_fall | input | 1 | One-cycle clear of the falling flag |
| rise_cap | output | CNT_W | Counter value at the last rising capture |
| fall_cap | output | CNT_W | Counter value at the last falling capture |
| rise_flag | output | 1 | Sticky rising-capture interrupt flag |
| fall_flag | output | 1 | Sticky falling-capture interrupt flag |
| irq | output | 1 | Capture interrupt request |
| cnt_load | output | 1 | One-cycle strobe that loads the period value into the counter |

## Verification
The bench samples one cycle early to confirm the three-edge latency. A design with one synchronizer stage too few would update a cycle early, and one with a stage too many would miss the sample point. It uses the extreme counts 0x0000 and 0xFFFF and a descending count sequence, so a design that sliced or swapped the count bits would be caught. It flips the pin while capture is disabled and then re-enables capture. A design that froze its synchronizer, or gated only the latch, would capture a false edge at that point. It also issues a flag clear in the same cycle as a flag set. It clears one flag while the other is set. A design that gave the clear priority, or shared one clear between both flags, would lose an interrupt.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int CAP_EDGES = 2;
  localparam int CAP_RISE  = 0;
  localparam int CAP_FALL  = 1;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic en,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] chain;
  logic         prev;

  // The chain keeps sampling while detection is off, so re-enabling
  // cannot produce an edge from a stale level.
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[MSB-1:0], pin};
      prev  <= chain[MSB];
    end
  end

  assign rise_ev = en &  chain[MSB] & ~prev;
  assign fall_ev = en & ~chain[MSB] &  prev;

  initial begin
    assert (STAGES >= 2) else $error("assert_stage_count_R9: need two stages");
  end
endmodule

// File: rtl/cap_latch.sv
module cap_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ev) q <= d;
  end

  assert_latch_only_on_edge_R1: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> $past(ev));
endmodule

// File: rtl/cap_flag.sv
module cap_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    set |=> q);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (q && !clr) |=> q);
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_pin,
  input  logic             cap_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             rise_ie,
  input  logic             fall_ie,
  input  logic             rise_rld_en,
  input  logic             fall_rld_en,
  input  logic             flag_clr_rise,
  input  logic             flag_clr_fall,
  output logic [CNT_W-1:0] rise_cap,
  output logic [CNT_W-1:0] fall_cap,
  output logic             rise_flag,
  output logic             fall_flag,
  output logic             irq,
  output logic             cnt_load
);
  logic [CAP_EDGES-1:0] edge_ev, edge_ie, edge_rld, edge_clr, edge_flag;
  logic [CNT_W-1:0]     cap_q [CAP_EDGES];

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(cap_pin), .en(cap_en),
    .rise_ev(edge_ev[CAP_RISE]), .fall_ev(edge_ev[CAP_FALL])
  );

  assign edge_ie[CAP_RISE]  = rise_ie;
  assign edge_ie[CAP_FALL]  = fall_ie;
  assign edge_rld[CAP_RISE] = rise_rld_en;
  assign edge_rld[CAP_FALL] = fall_rld_en;
  assign edge_clr[CAP_RISE] = flag_clr_rise;
  assign edge_clr[CAP_FALL] = flag_clr_fall;

  for (genvar e = 0; e < CAP_EDGES; e++) begin : g_edge
    cap_latch #(.W(CNT_W)) u_latch (
      .clk(clk), .rst(rst), .ev(edge_ev[e]), .d(cnt_val), .q(cap_q[e])
    );
    cap_flag u_flag (
      .clk(clk), .rst(rst), .set(edge_ev[e] & edge_ie[e]),
      .clr(edge_clr[e]), .q(edge_flag[e])
    );
  end

  // Strobe leaves with the latch update; the counter reloads one edge later,
  // so the stored count is always the pre-reload one.
  always_ff @(posedge clk) begin
    if (rst) cnt_load <= 1'b0;
    else     cnt_load <= |(edge_ev & edge_rld);
  end

  assign rise_cap  = cap_q[CAP_RISE];
  assign fall_cap  = cap_q[CAP_FALL];
  assign rise_flag = edge_flag[CAP_RISE];
  assign fall_flag = edge_flag[CAP_FALL];
  assign irq       = |edge_flag;

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> ($stable(rise_cap) && $stable(fall_cap) && !cnt_load));
  assert_load_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_load |-> $past(rise_rld_en || fall_rld_en));
  assert_rise_flag_gated_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rise_flag) |-> $past(rise_ie));
  assert_fall_flag_gated_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(fall_flag) |-> $past(fall_ie));
  assert_edge_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(!$stable(rise_cap) && !$stable(fall_cap)));
endmodule

// File: tb/cap_unit_bench.sv
module cap_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_pin = 1'b0, cap_en = 1'b0;
  logic [15:0] cnt_val = '0;
  logic        rise_ie = 0, fall_ie = 0, rise_rld_en = 0, fall_rld_en = 0;
  logic        flag_clr_rise = 0, flag_clr_fall = 0;
  logic [15:0] rise_cap, fall_cap;
  logic        rise_flag, fall_flag, irq, cnt_load;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] exp_r = '0, exp_f = '0;

  always #5 clk = ~clk;

  cap_unit u_cap_unit (.*);

  // {level, irq enable, reload enable, count}
  localparam logic [18:0] VEC [0:7] = '{
    {1'b1, 1'b1, 1'b0, 16'h1234}, {1'b0, 1'b1, 1'b1, 16'h0000},
    {1'b1, 1'b0, 1'b1, 16'hFFFF}, {1'b0, 1'b0, 1'b0, 16'h8001},
    {1'b1, 1'b1, 1'b1, 16'h7FFE}, {1'b0, 1'b1, 1'b0, 16'h7FF0},
    {1'b1, 1'b0, 1'b0, 16'h00FF}, {1'b0, 1'b1, 1'b1, 16'h00FE}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Drive pin, confirm nothing moved after two edges, land on the third.
  task automatic do_edge(input logic lvl, input logic [15:0] cv, input logic clr_same);
    @(negedge clk); cap_pin = lvl; cnt_val = cv;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R9 early rise_cap", rise_cap, exp_r);
    chk("R9 early fall_cap", fall_cap, exp_f);
    chk("R9 early load", cnt_load, 0);
    if (clr_same) begin flag_clr_rise = lvl; flag_clr_fall = !lvl; end
    @(posedge clk); @(negedge clk);
    flag_clr_rise = 0; flag_clr_fall = 0;
  endtask

  task automatic pulse_clr(input logic cr, input logic cf);
    @(negedge clk); flag_clr_rise = cr; flag_clr_fall = cf;
    @(negedge clk); flag_clr_rise = 0; flag_clr_fall = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R8 rise_cap", rise_cap, 0);
    chk("R8 fall_cap", fall_cap, 0);
    chk("R8 flags", {rise_flag, fall_flag, irq, cnt_load}, 0);
    cap_en = 1;

    for (int i = 0; i < 8; i++) begin
      logic lv, ie, rl;
      logic [15:0] cv;
      {lv, ie, rl, cv} = VEC[i];
      pulse_clr(1, 1);
      rise_ie = ie; fall_ie = ie; rise_rld_en = rl; fall_rld_en = rl;
      do_edge(lv, cv, 0);
      if (lv) exp_r = cv; else exp_f = cv;
      chk("R1 rise_cap", rise_cap, exp_r);
      chk("R2 fall_cap", fall_cap, exp_f);
      chk("R3 rise_flag", rise_flag, lv & ie);
      chk("R3 fall_flag", fall_flag, !lv & ie);
      chk("R3 irq", irq, ie);
      chk("R4 load", cnt_load, rl);
      @(negedge clk);
      chk("R4 load one cycle", cnt_load, 0);
    end

    // R6: both flags set, clear only rising, then stickiness
    pulse_clr(1, 1);
    rise_ie = 1; fall_ie = 1; rise_rld_en = 0; fall_rld_en = 0;
    do_edge(1, 16'hA5A5, 0); exp_r = 16'hA5A5;
    do_edge(0, 16'h5A5A, 0); exp_f = 16'h5A5A;
    repeat (5) @(negedge clk);
    chk("R6 both sticky", {rise_flag, fall_flag}, 2'b11);
    pulse_clr(1, 0);
    chk("R6 rise cleared", rise_flag, 0);
    chk("R6 fall kept", fall_flag, 1);
    pulse_clr(0, 1);
    chk("R6 fall cleared", {fall_flag, irq}, 0);

    // R7: clear in same cycle as set
    do_edge(1, 16'h0F0F, 1); exp_r = 16'h0F0F;
    chk("R7 set wins", rise_flag, 1);
    chk("R7 capture", rise_cap, 16'h0F0F);
    pulse_clr(1, 1);

    // R5: disabled, pin changes, then re-enable
    cap_en = 0; rise_rld_en = 1; fall_rld_en = 1;
    @(negedge clk); cap_pin = 0; cnt_val = 16'h1111;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (cnt_load) chk("R5 no load disabled", cnt_load, 0);
    end
    chk("R5 fall_cap held", fall_cap, exp_f);
    chk("R5 no flag", {rise_flag, fall_flag}, 0);
    cap_en = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (cnt_load) chk("R5 no load on re-enable", cnt_load, 0);
    end
    chk("R5 rise_cap held", rise_cap, exp_r);
    chk("R5 fall_cap still held", fall_cap, exp_f);
    chk("R5 no flag re-enable", {rise_flag, fall_flag}, 0);
    do_edge(1, 16'h2222, 0); exp_r = 16'h2222;
    chk("R5 capture resumes", rise_cap, 16'h2222);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule